// File: doc/BRIEF.md
# Sample-Store Direct-Mapped Cache

This block is a direct-mapped cache that holds sampled elements of the factor matrices used to rebuild low-rank data. Entries are written only by sample-load fill transactions. A fill writes one complete 64-byte line together with its tag, and it sets the line's valid bit. Nothing else modifies the stored contents.

A read request looks up one line. One cycle later the block returns the hit flag and the whole line as 16 parallel 32-bit elements, so that a downstream array of multipliers can consume every element in the same cycle.

The block keeps the cached samples exclusive to itself. For every fill it emits a one-cycle invalidate strobe that carries the filled line address, and the rest of the memory hierarchy uses this strobe to drop any copy of that line. A fill to an index that already holds a valid line replaces that line silently. There is no write-back.

Top module: `sample_store_cache`

## Requirements
- R1: While `rst_n` is low, every valid bit is cleared and `rd_out_valid`, `rd_hit` and `inv_valid` are low. After reset, a read of any address misses until a fill has written that line.
- R2: An address is split into three fields. Bits [5:0] are the byte offset, bits [9:6] (with 16 lines) are the index, and bits [31:10] are the tag. A read hits only when the indexed line is valid and its stored tag equals the address tag.
- R3: A fill (`fill_valid` high) writes all 512 bits of `fill_data` and the tag of `fill_addr` into the indexed line. A later read of the same line hits and returns exactly those 512 bits.
- R4: Lane i of the line, bits [32*i+31:32*i] of `fill_data` and `rd_data`, is 32-bit word i of the line. Word i covers bytes 4*i to 4*i+3.
- R5: Reads have a latency of one cycle. `rd_out_valid`, `rd_hit` and `rd_data` update at the clock edge that samples `rd_valid`. `rd_out_valid` is high for exactly the cycles that follow a cycle with `rd_valid` high.
- R6: On a miss, `rd_hit` is 0 and `rd_data` is all zero.
- R7: A fill to an index that holds a valid line with a different tag replaces that line. A read with the old tag then misses.
- R8: Each fill produces `inv_valid` high for one cycle, in the cycle after the fill, with `inv_line` equal to `fill_addr[31:6]`. `inv_valid` is low in any cycle not preceded by a fill. Back-to-back fills give back-to-back strobes.
- R9: When a read and a fill target the same index in the same cycle, the read returns the contents the line held before that fill.
- R10: The offset bits of `rd_addr` and `fill_addr` have no effect on lookup or storage. Any offset within a filled line hits that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | Sample-load fill request |
| fill_addr | input | 32 | Byte address of the line to fill |
| fill_data | input | 512 | Full line, lane i = word i |
| rd_valid | input | 1 | Read request |
| rd_addr | input | 32 | Byte address to look up |
| rd_out_valid | output | 1 | Read result valid, one cycle after the request |
| rd_hit | output | 1 | Read result hit flag |
| rd_data | output | 512 | Read line as 16 lanes of 32 bits, zero on miss |
| inv_valid | output | 1 | Exclusivity invalidate strobe |
| inv_line | output | 26 | Line address of the invalidate |

## Verification
Random traffic draws tags from a small pool over all 16 indices and mixes fills and reads, so that hits, cold misses and conflict evictions all occur often. Against a bench model, these sequences show whether tag comparison and valid tracking are correct, rather than only whether data was stored. Directed cases cover the following:
- a sweep of reads after reset, which shows whether valid bits were really cleared;
- distinct per-lane patterns, which separate lane ordering from whole-line storage;
- reads at varied offsets, which show that the offset bits take no part in lookup;
- a same-cycle read and fill to one index, which shows whether the read returns the contents from before the fill or after it.

// File: rtl/sscache_pkg.sv
package sscache_pkg;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_LINES  = 16;
  localparam int unsigned DEF_ELEM_W = 32;
  localparam int unsigned DEF_LANES  = 16;

  function automatic int unsigned offset_bits(input int unsigned lanes, input int unsigned elem_w);
    return $clog2(lanes * elem_w / 8);
  endfunction
endpackage

// File: rtl/sscache_tags.sv
module sscache_tags #(
  parameter int unsigned LINES = 16,
  parameter int unsigned TAG_W = 22,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit
);
  logic [LINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  // R3: a fill leaves its line valid
  a_r3_fill_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)]);
endmodule

// File: rtl/sscache_lines.sv
module sscache_lines #(
  parameter int unsigned LINES  = 16,
  parameter int unsigned LANES  = 16,
  parameter int unsigned ELEM_W = 32,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned LINE_W = LANES * ELEM_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line
);
  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [ELEM_W-1:0] word_q [LINES];

    always_ff @(posedge clk) begin
      if (wr_en) word_q[wr_idx] <= wr_line[g*ELEM_W +: ELEM_W];
    end

    assign rd_line[g*ELEM_W +: ELEM_W] = word_q[rd_idx];
  end
endmodule

// File: rtl/sample_store_cache.sv
module sample_store_cache #(
  parameter int unsigned ADDR_W = sscache_pkg::DEF_ADDR_W,
  parameter int unsigned LINES  = sscache_pkg::DEF_LINES,
  parameter int unsigned LANES  = sscache_pkg::DEF_LANES,
  parameter int unsigned ELEM_W = sscache_pkg::DEF_ELEM_W,
  localparam int unsigned OFF_W  = sscache_pkg::offset_bits(LANES, ELEM_W),
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int unsigned LA_W   = ADDR_W - OFF_W,
  localparam int unsigned LINE_W = LANES * ELEM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [LINE_W-1:0] fill_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_out_valid,
  output logic              rd_hit,
  output logic [LINE_W-1:0] rd_data,
  output logic              inv_valid,
  output logic [LA_W-1:0]   inv_line
);
  logic [LA_W-1:0]   fill_la, rd_la;
  logic [IDX_W-1:0]  fill_idx, rd_idx;
  logic [TAG_W-1:0]  fill_tag, rd_tag;
  logic              lk_hit;
  logic [LINE_W-1:0] lk_line;
  logic              unused_offsets;

  assign fill_la  = fill_addr[ADDR_W-1:OFF_W];
  assign rd_la    = rd_addr[ADDR_W-1:OFF_W];
  assign fill_idx = fill_la[IDX_W-1:0];
  assign rd_idx   = rd_la[IDX_W-1:0];
  assign fill_tag = fill_la[LA_W-1:IDX_W];
  assign rd_tag   = rd_la[LA_W-1:IDX_W];
  assign unused_offsets = ^{fill_addr[OFF_W-1:0], rd_addr[OFF_W-1:0]};

  sscache_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .wr_en(fill_valid), .wr_idx(fill_idx), .wr_tag(fill_tag),
    .lk_idx(rd_idx), .lk_tag(rd_tag), .lk_hit(lk_hit)
  );

  sscache_lines #(.LINES(LINES), .LANES(LANES), .ELEM_W(ELEM_W)) u_lines (
    .clk(clk),
    .wr_en(fill_valid), .wr_idx(fill_idx), .wr_line(fill_data),
    .rd_idx(rd_idx), .rd_line(lk_line)
  );

  logic              out_valid_d, hit_d, inv_valid_d;
  logic [LINE_W-1:0] data_d;
  logic [LA_W-1:0]   inv_line_d;

  always_comb begin
    out_valid_d = rd_valid;
    hit_d       = rd_hit;
    data_d      = rd_data;
    if (rd_valid) begin
      hit_d  = lk_hit;
      data_d = lk_hit ? lk_line : '0;
    end
    inv_valid_d = fill_valid;
    inv_line_d  = fill_valid ? fill_la : inv_line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_out_valid <= 1'b0;
      rd_hit       <= 1'b0;
      rd_data      <= '0;
      inv_valid    <= 1'b0;
      inv_line     <= '0;
    end else begin
      rd_out_valid <= out_valid_d;
      rd_hit       <= hit_d;
      rd_data      <= data_d;
      inv_valid    <= inv_valid_d;
      inv_line     <= inv_line_d;
    end
  end

  // R8: every fill is followed by one strobe carrying its line address
  a_r8_inv_follows_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> (inv_valid && inv_line == $past(fill_addr[ADDR_W-1:OFF_W])));
  // R8: no strobe without a fill
  a_r8_no_spurious_inv: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_valid |=> !inv_valid);
  // R5: result valid exactly one cycle after a request
  a_r5_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_out_valid);
  a_r5_no_result_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rd_out_valid);
  // R6: miss returns zeros
  a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_out_valid && !rd_hit) |-> (rd_data == '0));
  // R3: a read of the line filled in the previous cycle hits
  a_r3_hit_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fill_valid) && rd_valid && (rd_addr[ADDR_W-1:OFF_W] == $past(fill_addr[ADDR_W-1:OFF_W])))
    |=> rd_hit);
endmodule

// File: tb/sample_store_cache_tb.sv
`timescale 1ns/1ps
module sample_store_cache_tb;
  localparam int NL = 16;
  localparam int LW = 512;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           fill_valid;
  logic [31:0]    fill_addr;
  logic [LW-1:0]  fill_data;
  logic           rd_valid;
  logic [31:0]    rd_addr;
  logic           rd_out_valid, rd_hit, inv_valid;
  logic [LW-1:0]  rd_data;
  logic [25:0]    inv_line;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  bit            m_valid [NL];
  logic [21:0]   m_tag   [NL];
  logic [LW-1:0] m_data  [NL];

  always #10 clk = ~clk;

  sample_store_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_out_valid(rd_out_valid), .rd_hit(rd_hit), .rd_data(rd_data),
    .inv_valid(inv_valid), .inv_line(inv_line)
  );

  function automatic int idx_of(input logic [31:0] a);
    return int'(a[9:6]);
  endfunction
  function automatic logic [21:0] tag_of(input logic [31:0] a);
    return a[31:10];
  endfunction
  function automatic logic [LW-1:0] rand_line();
    logic [LW-1:0] l;
    for (int i = 0; i < 16; i++) l[i*32 +: 32] = $urandom;
    return l;
  endfunction
  function automatic logic [31:0] mk_addr(input logic [21:0] t, input int ix, input int off);
    return {t, 4'(ix), 6'(off)};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input bit fv, input logic [31:0] fa, input logic [LW-1:0] fd,
                      input bit rv, input logic [31:0] ra, input string rq);
    bit            e_hit;
    logic [LW-1:0] e_data;
    fill_valid = fv; fill_addr = fa; fill_data = fd;
    rd_valid = rv; rd_addr = ra;
    e_hit  = m_valid[idx_of(ra)] && (m_tag[idx_of(ra)] == tag_of(ra));
    e_data = e_hit ? m_data[idx_of(ra)] : '0;
    if (fv) begin
      m_valid[idx_of(fa)] = 1'b1;
      m_tag[idx_of(fa)]   = tag_of(fa);
      m_data[idx_of(fa)]  = fd;
    end
    @(posedge clk);
    @(negedge clk);
    chk(rd_out_valid == rv, "R5", "rd_out_valid", LW'(rd_out_valid), LW'(rv));
    if (rv) begin
      chk(rd_hit == e_hit, rq, "rd_hit", LW'(rd_hit), LW'(e_hit));
      chk(rd_data == e_data, e_hit ? rq : "R6", "rd_data", rd_data, e_data);
    end
    chk(inv_valid == fv, "R8", "inv_valid", LW'(inv_valid), LW'(fv));
    if (fv) chk(inv_line == fa[31:6], "R8", "inv_line", LW'(inv_line), LW'(fa[31:6]));
  endtask

  task automatic idle();
    step(1'b0, '0, '0, 1'b0, '0, "R5");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R5 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [21:0]   pool [3];
    logic [LW-1:0] ln;
    logic [31:0]   a;
    void'($urandom(32'h5A17));
    for (int i = 0; i < NL; i++) begin m_valid[i] = 1'b0; m_tag[i] = '0; m_data[i] = '0; end
    rst_n = 1'b0; fill_valid = 1'b0; fill_addr = '0; fill_data = '0; rd_valid = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    chk(!rd_out_valid && !rd_hit && !inv_valid, "R1", "reset outputs",
        LW'({rd_out_valid, rd_hit, inv_valid}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: every index misses after reset
    for (int i = 0; i < NL; i++) step(1'b0, '0, '0, 1'b1, mk_addr(22'h0, i, 0), "R1");

    // R3/R4: fill with lane-tagged words, read back, inspect each lane
    for (int i = 0; i < 16; i++) ln[i*32 +: 32] = 32'hA5000000 | 32'(i);
    step(1'b1, mk_addr(22'h123, 5, 0), ln, 1'b0, '0, "R3");
    step(1'b0, '0, '0, 1'b1, mk_addr(22'h123, 5, 0), "R3");
    for (int i = 0; i < 16; i++)
      chk(rd_data[i*32 +: 32] == (32'hA5000000 | 32'(i)), "R4", "lane word",
          LW'(rd_data[i*32 +: 32]), LW'(32'hA5000000 | 32'(i)));

    // R10: other offsets hit the same line
    step(1'b0, '0, '0, 1'b1, mk_addr(22'h123, 5, 63), "R10");
    step(1'b0, '0, '0, 1'b1, mk_addr(22'h123, 5, 17), "R10");
    // R2: same index, different tag misses
    step(1'b0, '0, '0, 1'b1, mk_addr(22'h124, 5, 0), "R2");

    // R7: conflicting fill replaces; old tag misses
    step(1'b1, mk_addr(22'h3FF, 5, 9), rand_line(), 1'b0, '0, "R7");
    step(1'b0, '0, '0, 1'b1, mk_addr(22'h123, 5, 0), "R7");
    step(1'b0, '0, '0, 1'b1, mk_addr(22'h3FF, 5, 0), "R7");

    // R9: same-cycle read and fill to one index returns old contents
    step(1'b1, mk_addr(22'h055, 5, 0), rand_line(), 1'b1, mk_addr(22'h3FF, 5, 4), "R9");
    step(1'b0, '0, '0, 1'b1, mk_addr(22'h055, 5, 0), "R9");
    step(1'b1, mk_addr(22'h077, 9, 0), rand_line(), 1'b1, mk_addr(22'h077, 9, 0), "R9");

    // R8: back-to-back fills give back-to-back strobes
    step(1'b1, mk_addr(22'h001, 1, 0), rand_line(), 1'b0, '0, "R8");
    step(1'b1, mk_addr(22'h002, 2, 3), rand_line(), 1'b0, '0, "R8");
    idle();

    // R3/R2/R7 random traffic over a small tag pool
    pool[0] = 22'h00A; pool[1] = 22'h2B1; pool[2] = 22'h3C4;
    for (int n = 0; n < 3000; n++) begin
      bit fv, rv;
      fv = ($urandom % 10) < 4;
      rv = ($urandom % 10) < 6;
      a  = mk_addr(pool[$urandom % 3], int'($urandom % NL), int'($urandom % 64));
      step(fv, a, rand_line(), rv,
           mk_addr(pool[$urandom % 3], int'($urandom % NL), int'($urandom % 64)), "R3");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule